// File: doc/BRIEF.md
# Bit Scatter Unit

This multi-cycle unit spreads the low-order bits of a source word across a destination word. A mask chooses the destination positions. Source bit 0 goes to the lowest set bit of the mask, source bit 1 goes to the next set bit, and so on upward. Every destination bit whose mask bit is clear reads zero.

The unit takes one mask bit per clock. It never walks over the clear positions of the mask. In each step it isolates the lowest remaining set bit by ANDing the working mask with its two's-complement negation, then removes that bit with an XOR. A one-hot selector picks the matching source bit. The selector starts at one and doubles each step, so no variable shifter is needed. Negating the selected source bit spreads it across all higher positions. That value is ANDed with the isolated mask bit and ORed into the result.

A caller raises `start` for one cycle with the operands. It then waits for the one-cycle `done` pulse and reads `result`, which holds steady until the next accepted start.

Top module: `bit_scatter_unit`

## Requirements
- R1: Source bit j appears at the position of the j-th set bit of the mask, counting set bits from bit 0 upward. For example, mask 0x0000002E with source 0x00000006 gives 0x0000000C, and mask 0x00000099 with source 0x0000000D gives 0x00000091.
- R2: Every result bit whose mask bit is clear is zero.
- R3: If `start` is accepted at clock edge k and the mask has p set bits with p at least 1, `done` goes high just after edge k+p. `busy` is high from edge k+1 until that same edge, where it falls.
- R4: An all-zero mask raises `done` just after edge k+1 with a result of zero.
- R5: Source bits at positions equal to or above the mask's population count have no effect on the result.
- R6: A `start` raised while `busy` is high is ignored. The running operation completes with its original operands.
- R7: `done` is high for exactly one cycle. `result` keeps its value from that pulse until the next accepted `start`.
- R8: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the unit is idle |
| srcWord | input | 32 | Bits to be scattered, sampled on an accepted start |
| maskWord | input | 32 | Destination positions, sampled on an accepted start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 32 | Scattered bits, held until the next accepted start |

## Verification
The in-RTL assertions check several properties on every cycle:
- the working mask loses exactly one set bit per step;
- the partial result never overlaps positions still waiting in the working mask;
- the source selector stays one-hot or empty;
- `done` lasts one cycle, and `busy` only falls together with `done`;
- the result stays unchanged whenever no load or step occurs.

Only the bench's scenarios can show the following:
- the full mapping of source bits to mask positions;
- the exact latency per population count;
- that high source bits are ignored;
- that a start issued mid-operation does not disturb the running operands.

// File: rtl/scatter_pkg.sv
package scatter_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands, clear result
    logic step;   // process lowest set bit of working mask
  } scatterStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic maskEmpty;  // working mask is zero
    logic lastBit;    // working mask holds exactly one set bit
  } scatterStatus_t;

endpackage

// File: rtl/scatter_ctrl.sv
module scatter_ctrl
  import scatter_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  scatterStatus_t status,
  output scatterStrobe_t strobe,
  output logic           busy,
  output logic           done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  logic       finish;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN) && !status.maskEmpty;
    finish      = (state == ST_RUN) && (status.maskEmpty || status.lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (strobe.load)
        state <= ST_RUN;
      else if (finish)
        state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_RUN);

  // R7: completion strobe lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: busy only drops together with the completion strobe
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R6: a start seen while busy never produces a load
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !finish) |=> busy);

endmodule

// File: rtl/scatter_datapath.sv
module scatter_datapath
  import scatter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  scatterStrobe_t      strobe,
  input  logic [DATA_W-1:0]   srcIn,
  input  logic [DATA_W-1:0]   maskIn,
  output scatterStatus_t      status,
  output logic [DATA_W-1:0]   resultOut
);

  localparam logic [DATA_W-1:0] SEL_INIT = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] workMask;
  logic [DATA_W-1:0] srcReg;
  logic [DATA_W-1:0] selBit;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] lowBit;
  logic [DATA_W-1:0] spread;

  always_comb begin
    lowBit           = workMask & (-workMask);
    spread           = -(srcReg & selBit);
    status.maskEmpty = (workMask == '0);
    status.lastBit   = !status.maskEmpty && ((workMask ^ lowBit) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workMask  <= '0;
      srcReg    <= '0;
      selBit    <= SEL_INIT;
      resultReg <= '0;
    end else if (strobe.load) begin
      workMask  <= maskIn;
      srcReg    <= srcIn;
      selBit    <= SEL_INIT;
      resultReg <= '0;
    end else if (strobe.step) begin
      workMask  <= workMask ^ lowBit;
      selBit    <= selBit + selBit;
      resultReg <= resultReg | (lowBit & spread);
    end
  end

  assign resultOut = resultReg;

  // R3: each step removes exactly one set bit from the working mask
  p_mask_shrinks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=>
      ($countones(workMask) + 1 == $countones($past(workMask))));

  // R2: deposited bits never land on positions still pending
  p_result_disjoint_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resultReg & workMask) == '0);

  // R1: source selector is one-hot (or shifted out past the top)
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selBit));

  // R7: result only changes on load or step
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(resultReg));

endmodule

// File: rtl/bit_scatter_unit.sv
module bit_scatter_unit
  import scatter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] maskWord,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  scatterStrobe_t strobe;
  scatterStatus_t status;

  scatter_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  scatter_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcIn     (srcWord),
    .maskIn    (maskWord),
    .status    (status),
    .resultOut (result)
  );

endmodule

// File: tb/bit_scatter_unit_bench.sv
module bit_scatter_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] srcWord = '0;
  logic [31:0] maskWord = '0;
  logic        busy;
  logic        done;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  bit_scatter_unit u_bit_scatter_unit (
    .clk(clk), .rstN(rstN), .start(start), .srcWord(srcWord),
    .maskWord(maskWord), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] refScatter(logic [31:0] s, logic [31:0] m);
    logic [31:0] r = '0;
    int k = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        r[i] = s[k];
        k++;
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally fires a stray start mid-run (R6).
  task automatic runOp(logic [31:0] s, logic [31:0] m, bit inject,
                       output logic [31:0] res);
    int cyc = 0;
    int expLat;
    bit busyOk = 1'b1;
    logic [31:0] held;
    expLat = ($countones(m) == 0) ? 1 : $countones(m);
    @(negedge clk);
    srcWord = s; maskWord = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (!done && !busy) busyOk = 1'b0;
      if (inject && cyc == 1 && !done) begin
        start = 1'b1; srcWord = ~s; maskWord = ~m;
      end
    end while (!done && cyc < 100);
    start = 1'b0;
    res = result;
    check(cyc == expLat, "R3 latency", cyc, expLat);
    check(busyOk && !busy, "R3 busy", {31'b0, busy}, 32'h0);
    check(result == refScatter(s, m), "R1 mapping", result, refScatter(s, m));
    check((result & ~m) == 0, "R2 outside mask", result & ~m, 32'h0);
    held = result;
    @(negedge clk);
    check(!done, "R7 done pulse", {31'b0, done}, 32'h0);
    @(negedge clk);
    check(result == held, "R7 result held", result, held);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, r2, s, m, lowMask;
    int p;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!busy && !done && result == 0, "R8 reset", result, 32'h0);
    rstN = 1'b1;

    runOp(32'h6, 32'h2E, 1'b0, r);          // R1 example
    check(r == 32'h0C, "R1 example a", r, 32'h0C);
    runOp(32'hD, 32'h99, 1'b0, r);          // R1 example
    check(r == 32'h91, "R1 example b", r, 32'h91);
    runOp(32'hFFFFFFFF, 32'h0, 1'b0, r);    // R4 zero mask
    check(r == 0, "R4 zero mask", r, 32'h0);
    runOp(32'hA5A5A5A5, 32'hFFFFFFFF, 1'b0, r);
    runOp(32'h1, 32'h80000000, 1'b0, r);
    runOp(32'h0, 32'h80000000, 1'b0, r);
    runOp(32'h12345678, 32'h0F0F00F1, 1'b1, r);   // R6 stray start
    check(r == refScatter(32'h12345678, 32'h0F0F00F1), "R6 start ignored",
          r, refScatter(32'h12345678, 32'h0F0F00F1));

    for (int n = 0; n < 60; n++) begin
      s = $urandom;
      case (n % 3)
        0: m = $urandom;
        1: m = $urandom & $urandom & $urandom;
        default: m = $urandom | $urandom;
      endcase
      runOp(s, m, (n % 5 == 0), r);
      // R5: bits above the population count do not matter
      p = $countones(m);
      lowMask = (p >= 32) ? 32'hFFFFFFFF : ((32'h1 << p) - 1);
      runOp((s & lowMask) | ($urandom & ~lowMask), m, 1'b0, r2);
      check(r2 == r, "R5 high source bits ignored", r2, r);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule